// File: doc/BRIEF.md
# Zero-Stall Jump Program Sequencer

This block fetches instructions from a 256-word store and steps a program counter through it. On every running cycle it presents one address, split into a 2-bit row and a 6-bit column, to a synchronous instruction array. The word that comes back one cycle later is decoded at once. A word with its jump flag set steers that same cycle's fetch to the target it carries, so control transfers cost no idle cycle. Any other word lets the counter step by one.

A one-cycle start pulse begins execution and a one-cycle stop pulse ends it. Both are registered, so each takes effect from the cycle after the one in which it is sampled. While the sequencer is stopped, a write port loads words into the store. The fetched word, a valid flag and the row and column of the current fetch come out for the execution logic that follows.

Top module: `zs_sequencer`

## Requirements
- R1: After reset the sequencer is stopped (`fetch_en` low), `instr_valid` is low and `fetch_addr` is 0.
- R2: A `start` pulse sampled at a clock edge, with `stop` low, raises `fetch_en` from the following cycle. `fetch_en` stays low in the cycle in which `start` is presented.
- R3: While running, a fetch that is not redirected by a jump uses the address one above the previous fetch, and 255 is followed by 0.
- R4: A word is a jump exactly when bit 23 is 1. Its target is bits 7:0, with bit 7 as the most significant bit. Every other bit plays no part in the decode.
- R5: A word fetched in cycle t appears on `instr` with `instr_valid` high in cycle t+1. If that word is a jump, `fetch_addr` in cycle t+1 equals its target, with no idle cycle between them.
- R6: A chain of jump words, each one targeting the next, is followed at one address per cycle, and the sequencer never presents the same address twice in a row.
- R7: A `stop` pulse sampled at an edge lowers `fetch_en` from the following cycle. While stopped, `fetch_addr` keeps its value. `stop` wins over a simultaneous `start`.
- R8: If the last word fetched before a stop is a jump, `fetch_addr` equals its target while the sequencer is stopped, and a later start resumes fetching there.
- R9: `fetch_row` equals `fetch_addr[7:6]` and `fetch_col` equals `fetch_addr[5:0]`.
- R10: With `wr_en` high, `wr_data` is stored at `wr_addr` on the clock edge, and a later fetch of that address returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin-execution pulse |
| stop | input | 1 | Halt pulse, takes priority over start |
| wr_en | input | 1 | Store write enable |
| wr_addr | input | 8 | Store write address |
| wr_data | input | 24 | Store write data |
| fetch_en | output | 1 | A fetch is issued this cycle |
| fetch_addr | output | 8 | Address presented this cycle |
| fetch_row | output | 2 | Row part of the fetch address |
| fetch_col | output | 6 | Column part of the fetch address |
| instr | output | 24 | Word fetched in the previous cycle |
| instr_valid | output | 1 | `instr` holds a freshly fetched word |

## Verification
A stop request and a jump decode can fall in the same cycle. In that cycle the counter has already moved past the jump word, so the target must be captured while the fetch path is shutting down. The bench provokes this by raising `stop` exactly when the address being fetched holds a jump word. It then checks that the stopped sequencer presents the target and that the next start fetches from it. A second collision, `start` and `stop` in one cycle, is judged by `fetch_en` staying low.

// File: rtl/zs_sequencer.sv
module zs_sequencer #(
  parameter int AW       = 8,
  parameter int DW       = 24,
  parameter int ROW_W    = 2,
  parameter int FLAG_BIT = 23
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          fetch_en,
  output logic [AW-1:0] fetch_addr,
  output logic [ROW_W-1:0] fetch_row,
  output logic [AW-ROW_W-1:0] fetch_col,
  output logic [DW-1:0] instr,
  output logic          instr_valid
);
  localparam int COL_W = AW - ROW_W;
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [DW-1:0] word_q;
  logic          running, valid_q, take_jump;
  logic [AW-1:0] pc;

  assign take_jump  = valid_q & word_q[FLAG_BIT];
  assign fetch_addr = take_jump ? word_q[AW-1:0] : pc;
  assign fetch_en   = running;
  assign fetch_row  = fetch_addr[AW-1:COL_W];
  assign fetch_col  = fetch_addr[COL_W-1:0];
  assign instr      = word_q;
  assign instr_valid = valid_q;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (running) word_q <= store[fetch_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      valid_q <= 1'b0;
      pc      <= '0;
    end else begin
      running <= stop ? 1'b0 : (start ? 1'b1 : running);
      valid_q <= running;
      if (running) pc <= fetch_addr + 1'b1;
      else if (take_jump) pc <= word_q[AW-1:0];
    end
  end

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && start && !stop) |=> fetch_en); // R2
  AST_STOP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !fetch_en); // R7
  AST_PC_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> (pc == $past(fetch_addr) + 1'b1)); // R3
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_en && !instr_valid) |=> $stable(fetch_addr)); // R7
  AST_DATA_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_en |=> instr_valid); // R5
endmodule

// File: tb/sim_zs_sequencer.sv
`timescale 1ns/1ps
module sim_zs_sequencer;
  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, stop = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic fetch_en, instr_valid;
  logic [7:0] fetch_addr;
  logic [1:0] fetch_row;
  logic [5:0] fetch_col;
  logic [23:0] instr;

  zs_sequencer u0 (.clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fetch_en(fetch_en),
    .fetch_addr(fetch_addr), .fetch_row(fetch_row), .fetch_col(fetch_col),
    .instr(instr), .instr_valid(instr_valid));

  always #2 clk = ~clk;

  int checks = 0, failures = 0;
  int mmem [256];
  int mpc = 0, mword = 0;
  bit mrun = 0, mvalid = 0, prev_jump = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int word_for(input int i);
    case (i)
      3:   return 24'h80_000A;
      10:  return 24'hFF_FF28;
      41:  return 24'h80_0064;
      100: return 24'hC3_00C8;
      200: return 24'h80_00FA;
      default: return ((i * 37 + 5) * 4099 + i) & 24'h7F_FFFF;
    endcase
  endfunction

  function automatic int exp_addr();
    if (mvalid && mword[23]) return mword & 255;
    return mpc;
  endfunction

  task automatic step(input bit st, input bit sp, input bit we, input int wa, input int wd);
    int ea;
    bit jmp;
    ea = exp_addr();
    jmp = mvalid && mword[23];
    check(fetch_en === mrun, mrun ? "R2 fetch_en" : "R7 fetch_en", fetch_en, mrun);
    if (!mrun && jmp)
      check(fetch_addr == ea[7:0], "R8 held target", fetch_addr, ea);
    else if (jmp && prev_jump)
      check(fetch_addr == ea[7:0], "R6 chained jump", fetch_addr, ea);
    else if (jmp)
      check(fetch_addr == ea[7:0], "R5 R4 jump redirect", fetch_addr, ea);
    else
      check(fetch_addr == ea[7:0], mrun ? "R3 advance" : "R7 hold", fetch_addr, ea);
    check({fetch_row, fetch_col} == fetch_addr && fetch_row == ea[7:6] && fetch_col == ea[5:0],
          "R9 row/col", {fetch_row, fetch_col}, ea);
    check(instr_valid === mvalid, "R5 instr_valid", instr_valid, mvalid);
    if (mvalid) check(instr == mword[23:0], "R10 R5 instr data", instr, mword);
    if (mrun) prev_jump = jmp; else prev_jump = 0;
    start = st; stop = sp; wr_en = we; wr_addr = wa[7:0]; wr_data = wd[23:0];
    @(posedge clk);
    if (mrun) begin
      mword = mmem[ea];
      mpc = (ea + 1) % 256;
    end else if (jmp) mpc = ea;
    mvalid = mrun;
    mrun = sp ? 0 : (st ? 1 : mrun);
    if (we) mmem[wa] = wd;
    @(negedge clk);
    start = 0; stop = 0; wr_en = 0;
  endtask

  initial begin
    #(4 * 200000);
    check(0, "watchdog", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mmem[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check(fetch_en === 1'b0, "R1 fetch_en", fetch_en, 0);
    check(instr_valid === 1'b0, "R1 instr_valid", instr_valid, 0);
    check(fetch_addr == 8'd0, "R1 fetch_addr", fetch_addr, 0);
    for (int i = 0; i < 256; i++) step(0, 0, 1, i, word_for(i));
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 60; k++) step(0, 0, 0, 0, 0);
    // stop on the same cycle a jump word is fetched
    for (int k = 0; k < 40; k++) begin
      if (mrun && mmem[exp_addr()][23]) begin
        step(0, 1, 0, 0, 0);
        break;
      end
      step(0, 0, 0, 0, 0);
    end
    check(mvalid && mword[23] && !mrun, "R8 collision reached", mvalid, 1);
    for (int k = 0; k < 5; k++) step(0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 25; k++) step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0);
    step(1, 1, 0, 0, 0);
    for (int k = 0; k < 3; k++) step(0, 0, 0, 0, 0);
    step(0, 0, 1, 252, 24'h81_0000);
    step(0, 0, 1, 2, 24'h12_3456);
    step(1, 0, 0, 0, 0);
    for (int k = 0; k < 80; k++) step(0, 0, 0, 0, 0);
    step(0, 1, 0, 0, 0);
    for (int k = 0; k < 4; k++) step(0, 0, 0, 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule